// File: doc/BRIEF.md
# Segment Table Address Translator with Protection Checks

This block turns a two-part logical address, a segment number plus an offset into that segment, into a physical address. The mapping comes from a small table held on chip. Each table entry stores four things: the physical start of the segment, the segment length, a present flag, and three access rights (read, write and execute). A separate register holds the number of segments that are in use. A request carries the segment number, the offset and the kind of access. One clock later the block returns one of two results. On a legal access the result is the segment start plus the offset. Otherwise it returns a trap with a cause code naming the first check that failed.

Software, or a neighbouring controller, fills the table through a configuration port. One write strobe loads one whole table entry. A second strobe loads the segment-count register. A write changes what lookups see from the next cycle on. A lookup made in the same cycle as a write still sees the old contents.

The response path is a two-state machine. `ST_IDLE` is the state with no result pending. `ST_RESP` is the state in which a registered result is presented. The transition `GO_RESP` is taken from either state whenever a request is sampled. The transition `GO_IDLE` is taken from either state when no request is sampled. `rsp_valid` is high exactly while the machine is in `ST_RESP`.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `rsp_valid` is low, the segment count is 0 and every table entry is marked absent, so the first lookup traps with cause 1.
- R2: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low in the cycle after each cycle with `req_valid` low.
- R3: A lookup whose segment number is greater than or equal to the segment count traps with cause 1 (segment out of range). This includes a segment number equal to the count.
- R4: A lookup of an in-range segment whose entry has its present flag at 0 traps with cause 2 (absent segment).
- R5: A lookup whose offset is greater than or equal to the entry's length traps with cause 3 (offset over limit). An entry of length 0 traps for every offset.
- R6: The access kind is encoded 0 for read, 1 for write, 2 for execute and 3 for reserved. The rights field uses bit 0 for read, bit 1 for write and bit 2 for execute. An access whose right bit is 0 traps with cause 4. Kind 3 always traps with cause 4.
- R7: When several checks fail, the reported cause is the first failing one in this order: range (1), absent (2), limit (3), rights (4).
- R8: A lookup that passes all checks returns trap 0, cause 0 and a physical address equal to start plus offset, taken modulo 2^PA_W.
- R9: A trapped response drives a physical address of 0.
- R10: A table entry write is seen by lookups from the cycle after the write. A lookup made in the same cycle as the write sees the previous entry.
- R11: A segment-count write follows the same timing as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | SEG_W | Segment number of the logical address |
| req_off | input | OFF_W | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | SEG_W | Table entry to write |
| cfg_base | input | PA_W | Physical start of the segment |
| cfg_len | input | OFF_W+1 | Segment length |
| cfg_present | input | 1 | Present flag for the entry |
| cfg_rights | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| cnt_we | input | 1 | Segment-count write strobe |
| cnt_val | input | SEG_W+1 | New segment count |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_trap | output | 1 | The lookup trapped |
| rsp_cause | output | 3 | 0 none, 1 range, 2 absent, 3 limit, 4 rights |
| rsp_paddr | output | PA_W | Physical address, 0 when trapped |

## Verification
The hardest case to reach is a lookup in the same cycle as a configuration write to the entry or count it depends on. That lookup must see the old value, and the next lookup must see the new one. The stimulus drives a request and a write in one cycle and checks the pair of responses that follow, for both the entry port and the count port. The other hard case is the priority order. It needs inputs that fail several checks at once: an absent entry accessed past its length with the reserved kind, a segment exactly at the count, and an offset over the limit with a forbidden kind. Each of these is built on purpose, so the reported cause shows the ordering.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        TC_NONE        = 3'd0,
        TC_SEG_RANGE   = 3'd1,
        TC_SEG_ABSENT  = 3'd2,
        TC_OFF_LIMIT   = 3'd3,
        TC_RIGHTS      = 3'd4
    } trap_cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    localparam int RIGHT_RD = 0;
    localparam int RIGHT_WR = 1;
    localparam int RIGHT_EX = 2;
    localparam int RIGHTS_W = 3;

endpackage

// File: rtl/seg_table_store.sv
module seg_table_store #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEG_W-1:0]     wr_idx,
    input  logic [PA_W-1:0]      wr_base,
    input  logic [OFF_W:0]       wr_len,
    input  logic                 wr_present,
    input  logic [2:0]           wr_rights,
    input  logic                 cnt_en,
    input  logic [SEG_W:0]       cnt_in,
    input  logic [SEG_W-1:0]     rd_idx,
    output logic [PA_W-1:0]      rd_base,
    output logic [OFF_W:0]       rd_len,
    output logic                 rd_present,
    output logic [2:0]           rd_rights,
    output logic [SEG_W:0]       seg_count
);
    localparam int NSEG = 1 << SEG_W;

    logic [PA_W-1:0]  base_q    [NSEG];
    logic [OFF_W:0]   len_q     [NSEG];
    logic             present_q [NSEG];
    logic [2:0]       rights_q  [NSEG];
    logic [SEG_W:0]   count_q;

    for (genvar e = 0; e < NSEG; e++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == SEG_W'(e));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[e]    <= '0;
                len_q[e]     <= '0;
                present_q[e] <= 1'b0;
                rights_q[e]  <= '0;
            end else if (hit) begin
                base_q[e]    <= wr_base;
                len_q[e]     <= wr_len;
                present_q[e] <= wr_present;
                rights_q[e]  <= wr_rights;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_en) begin
            count_q <= cnt_in;
        end
    end

    assign rd_base    = base_q[rd_idx];
    assign rd_len     = len_q[rd_idx];
    assign rd_present = present_q[rd_idx];
    assign rd_rights  = rights_q[rd_idx];
    assign seg_count  = count_q;

endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic [SEG_W-1:0]     seg,
    input  logic [OFF_W-1:0]     off,
    input  logic [1:0]           kind,
    input  logic [SEG_W:0]       seg_count,
    input  logic [PA_W-1:0]      base,
    input  logic [OFF_W:0]       len,
    input  logic                 present,
    input  logic [2:0]           rights,
    output logic [2:0]           cause,
    output logic [PA_W-1:0]      paddr
);
    logic        in_range;
    logic        in_limit;
    logic        allowed;
    trap_cause_e cause_e;

    assign in_range = ({1'b0, seg} < seg_count);
    assign in_limit = ({1'b0, off} < len);

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_READ:  allowed = rights[RIGHT_RD];
            ACC_WRITE: allowed = rights[RIGHT_WR];
            ACC_EXEC:  allowed = rights[RIGHT_EX];
            ACC_RSVD:  allowed = 1'b0;
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!in_range)       cause_e = TC_SEG_RANGE;
        else if (!present)   cause_e = TC_SEG_ABSENT;
        else if (!in_limit)  cause_e = TC_OFF_LIMIT;
        else if (!allowed)   cause_e = TC_RIGHTS;
        else                 cause_e = TC_NONE;
    end

    assign cause = cause_e;
    assign paddr = (cause_e == TC_NONE) ? (base + PA_W'(off)) : '0;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [SEG_W-1:0]     req_seg,
    input  logic [OFF_W-1:0]     req_off,
    input  logic [1:0]           req_kind,
    input  logic                 cfg_we,
    input  logic [SEG_W-1:0]     cfg_idx,
    input  logic [PA_W-1:0]      cfg_base,
    input  logic [OFF_W:0]       cfg_len,
    input  logic                 cfg_present,
    input  logic [2:0]           cfg_rights,
    input  logic                 cnt_we,
    input  logic [SEG_W:0]       cnt_val,
    output logic                 rsp_valid,
    output logic                 rsp_trap,
    output logic [2:0]           rsp_cause,
    output logic [PA_W-1:0]      rsp_paddr
);
    logic [PA_W-1:0] ent_base;
    logic [OFF_W:0]  ent_len;
    logic            ent_present;
    logic [2:0]      ent_rights;
    logic [SEG_W:0]  seg_count_q;
    logic [2:0]      chk_cause;
    logic [PA_W-1:0] chk_paddr;

    rsp_state_e state_q, state_d;

    seg_table_store #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_idx     (cfg_idx),
        .wr_base    (cfg_base),
        .wr_len     (cfg_len),
        .wr_present (cfg_present),
        .wr_rights  (cfg_rights),
        .cnt_en     (cnt_we),
        .cnt_in     (cnt_val),
        .rd_idx     (req_seg),
        .rd_base    (ent_base),
        .rd_len     (ent_len),
        .rd_present (ent_present),
        .rd_rights  (ent_rights),
        .seg_count  (seg_count_q)
    );

    seg_rights_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .seg       (req_seg),
        .off       (req_off),
        .kind      (req_kind),
        .seg_count (seg_count_q),
        .base      (ent_base),
        .len       (ent_len),
        .present   (ent_present),
        .rights    (ent_rights),
        .cause     (chk_cause),
        .paddr     (chk_paddr)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_trap  <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
        end else if (req_valid) begin
            rsp_trap  <= (chk_cause != 3'd0);
            rsp_cause <= chk_cause;
            rsp_paddr <= chk_paddr;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int SEG_W = 3,
    parameter int PA_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SEG_W-1:0]  req_seg,
    input logic [1:0]        req_kind,
    input logic [SEG_W:0]    seg_count_q,
    input logic              rsp_valid,
    input logic              rsp_trap,
    input logic [2:0]        rsp_cause,
    input logic [PA_W-1:0]   rsp_paddr
);
    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    seg_range_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= seg_count_q)) |=> (rsp_trap && rsp_cause == 3'd1));

    // R6
    rsvd_kind_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> rsp_trap);

    // R9
    trap_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap) |-> (rsp_paddr == '0));

    // R7
    cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_trap == (rsp_cause != 3'd0)) && rsp_cause <= 3'd4));

endmodule

bind seg_xlate_unit seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_seg     (req_seg),
    .req_kind    (req_kind),
    .seg_count_q (seg_count_q),
    .rsp_valid   (rsp_valid),
    .rsp_trap    (rsp_trap),
    .rsp_cause   (rsp_cause),
    .rsp_paddr   (rsp_paddr)
);

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;
    localparam int SEG_W = 3;
    localparam int OFF_W = 12;
    localparam int PA_W  = 16;
    localparam int NSEG  = 1 << SEG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0] req_kind = '0;
    logic cfg_we = 1'b0;
    logic [SEG_W-1:0] cfg_idx = '0;
    logic [PA_W-1:0] cfg_base = '0;
    logic [OFF_W:0] cfg_len = '0;
    logic cfg_present = 1'b0;
    logic [2:0] cfg_rights = '0;
    logic cnt_we = 1'b0;
    logic [SEG_W:0] cnt_val = '0;
    logic rsp_valid, rsp_trap;
    logic [2:0] rsp_cause;
    logic [PA_W-1:0] rsp_paddr;

    always #2.5 clk = ~clk;

    seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u0 (.*);

    typedef struct {
        logic            trap;
        logic [2:0]      cause;
        logic [PA_W-1:0] paddr;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [PA_W-1:0] m_base [NSEG];
    logic [OFF_W:0]  m_len  [NSEG];
    logic            m_pres [NSEG];
    logic [2:0]      m_rts  [NSEG];
    int              m_cnt;

    function automatic exp_t model(int seg, int off, int kind, string tag);
        exp_t e;
        logic ok;
        e.tag = tag;
        e.paddr = '0;
        ok = (kind != 3) && (kind < 3) && m_rts[seg][kind % 3];
        if (seg >= m_cnt)         e.cause = 3'd1;
        else if (!m_pres[seg])    e.cause = 3'd2;
        else if (off >= m_len[seg]) e.cause = 3'd3;
        else if (!ok)             e.cause = 3'd4;
        else                      e.cause = 3'd0;
        e.trap = (e.cause != 3'd0);
        if (!e.trap) e.paddr = PA_W'(m_base[seg] + PA_W'(off));
        return e;
    endfunction

    task automatic quiet_inputs();
        req_valid = 1'b0; cfg_we = 1'b0; cnt_we = 1'b0;
    endtask

    task automatic set_req(int seg, int off, int kind, string tag);
        req_valid = 1'b1;
        req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_kind = 2'(kind);
        exp_q.push_back(model(seg, off, kind, tag));
    endtask

    task automatic set_entry(int idx, int base, int len, bit pres, int rts);
        cfg_we = 1'b1; cfg_idx = SEG_W'(idx); cfg_base = PA_W'(base);
        cfg_len = (OFF_W+1)'(len); cfg_present = pres; cfg_rights = 3'(rts);
        m_base[idx] = PA_W'(base); m_len[idx] = (OFF_W+1)'(len);
        m_pres[idx] = pres; m_rts[idx] = 3'(rts);
    endtask

    task automatic set_count(int n);
        cnt_we = 1'b1; cnt_val = (SEG_W+1)'(n); m_cnt = n;
    endtask

    task automatic idle();
        @(negedge clk); quiet_inputs();
    endtask

    task automatic write_entry(int idx, int base, int len, bit pres, int rts);
        @(negedge clk); quiet_inputs(); set_entry(idx, base, len, pres, rts);
    endtask

    task automatic write_count(int n);
        @(negedge clk); quiet_inputs(); set_count(n);
    endtask

    task automatic lookup(int seg, int off, int kind, string tag);
        @(negedge clk); quiet_inputs(); set_req(seg, off, kind, tag);
    endtask

    // expectation taken before the model update: same-cycle lookup sees old state
    task automatic lookup_and_entry(int seg, int off, int kind, string tag,
                                    int idx, int base, int len, bit pres, int rts);
        @(negedge clk); quiet_inputs(); set_req(seg, off, kind, tag);
        set_entry(idx, base, len, pres, rts);
    endtask

    task automatic lookup_and_count(int seg, int off, int kind, string tag, int n);
        @(negedge clk); quiet_inputs(); set_req(seg, off, kind, tag); set_count(n);
    endtask

    // monitor: compares every response against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected response: got valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_trap !== e.trap || rsp_cause !== e.cause || rsp_paddr !== e.paddr) begin
                    fails++;
                    $display("FAIL %s: got trap=%0b cause=%0d paddr=%h expected trap=%0b cause=%0d paddr=%h",
                             e.tag, rsp_trap, rsp_cause, rsp_paddr, e.trap, e.cause, e.paddr);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got no completion, expected end of stimulus");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_base[i] = '0; m_len[i] = '0; m_pres[i] = 1'b0; m_rts[i] = '0;
        end
        m_cnt = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset valid: got %0b expected 0", rsp_valid);
        end
        rst_n = 1'b1;

        lookup(0, 0, 0, "R1 first lookup after reset");
        lookup(NSEG-1, 5, 2, "R1 last entry after reset");
        write_count(4);
        write_entry(0, 'h1000, 'h100, 1'b1, 3'b011);
        write_entry(1, 'hF800, 'h1000, 1'b1, 3'b100);
        write_entry(2, 'h2000, 'h10, 1'b0, 3'b111);
        write_entry(3, 'h0040, 0, 1'b1, 3'b111);
        write_entry(5, 'h3000, 'h20, 1'b1, 3'b001);
        idle();

        lookup(0, 'h0FF, 0, "R8 read at last legal offset");
        lookup(0, 'h100, 0, "R5 offset equal to length");
        lookup(0, 'h010, 1, "R8 write permitted");
        lookup(0, 'h010, 2, "R6 exec not permitted");
        lookup(0, 'h010, 3, "R6 reserved kind");
        lookup(1, 'hFFF, 2, "R8 exec with address wrap");
        lookup(1, 0, 0, "R6 read not permitted");
        lookup(2, 0, 0, "R4 absent entry");
        lookup(3, 0, 0, "R5 zero-length segment");
        lookup(5, 0, 0, "R3 segment above count");
        lookup(4, 0, 0, "R3 segment equal to count");
        lookup(2, 'h800, 3, "R7 absent beats limit and rights");
        lookup(0, 'h200, 2, "R7 limit beats rights");
        lookup(5, 'h800, 3, "R7 range beats all");
        idle();
        idle();
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2 idle gap: got valid=%0b expected 0", rsp_valid);
        end

        lookup_and_entry(0, 'h20, 0, "R10 same-cycle lookup sees old entry",
                         0, 'h1000, 'h100, 1'b1, 3'b100);
        lookup(0, 'h20, 0, "R10 next lookup sees new entry");
        lookup(0, 'h20, 2, "R10 new rights grant exec");
        lookup_and_count(5, 'h4, 0, "R11 same-cycle lookup sees old count", 6);
        lookup(5, 'h4, 0, "R11 next lookup sees new count");
        write_count(8);
        lookup(7, 0, 0, "R4 top entry absent with full count");
        lookup(5, 'h1F, 0, "R8 last offset of segment 5");
        idle();
        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing responses: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule